// File: doc/BRIEF.md
# Selectable March Test Engine

This block is a self-test sequencer for a single-port, bit-wide synchronous RAM of `WORDS` cells. A one-cycle `start` pulse, together with a 3-bit code, picks one of six March algorithms. The engine then runs that algorithm's elements in order. Within each element it walks every address in the element's direction. At each address it issues all of the element's reads and writes before it moves on. It issues one memory operation per clock, with no idle cycles, until the algorithm ends.

Each read is compared with its expected bit in the cycle after it is issued, because the RAM returns data one clock late. The first mismatch latches `fail`, the failing address and the 0-based element index. Later mismatches leave that record unchanged. The engine ends every run with a single-cycle `done` pulse, whether or not a read failed.

The algorithms come from small per-algorithm element tables. Each element holds up to three operations, a direction and a hammer flag per operation, so the sequencing logic is shared by all six algorithms.

Top module: `mbist_march_engine`

## Requirements
- R1: After reset, `done`, `fail`, `fail_addr`, `fail_elem`, `mem_we` and `mem_re` are all 0.
- R2: `alg_sel` codes select the algorithms as follows: 0 SCAN (4n operations), 1 MATS+ (5n), 2 MATS++ (6n), 3 March C- (10n), 4 PMOVI (13n), 5 Hammer (49n), where n = `WORDS`.
- R3: The elements and their directions are as follows (U means address 0 up to n-1, D means n-1 down to 0):
  - SCAN: U w0; U r0; U w1; U r1.
  - MATS+: U w0; U (r0,w1); D (r1,w0).
  - MATS++: U w0; U (r0,w1); D (r1,w0,r0).
  - March C-: U w0; U (r0,w1); U (r1,w0); D (r0,w1); D (r1,w0); U r0.
  - PMOVI: D w0; U (r0,w1,r1); U (r1,w0,r0); D (r0,w1,r1); D (r1,w0,r0).
  - Hammer: U w0; U (r0,w1,r1); U (r1,w0,r0); D (r0,w1,r1); D (r1,w0,r0).
- R4: All operations of an element are issued at one address before the address steps. The first operation appears in the cycle after `start` is sampled, and exactly one of `mem_we`/`mem_re` is high in every cycle until the last operation.
- R5: In Hammer, the middle write of each element after the first is issued `HAMMER_REP` (default 10) times in consecutive cycles at the same address.
- R6: `mem_rdata` is compared with the expected bit one cycle after the read is issued. A mismatch raises `fail` one cycle after that.
- R7: Only the first mismatch is recorded: `fail_addr` gets its address and `fail_elem` its 0-based element index. `fail`, `fail_addr` and `fail_elem` hold until the next accepted start.
- R8: `done` is high for exactly one cycle. That cycle is the second cycle after the last operation, and the cycle between them issues no operation. When `done` is high, `fail` and its record are final.
- R9: `start` is ignored while a run is in progress, and when `alg_sel` is 6 or 7. An ignored start causes no memory operation and no `done`, and does not change `fail`.
- R10: An accepted start clears `fail`, `fail_addr` and `fail_elem`, so `fail` is 0 in the cycle of the first operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| alg_sel | input | 3 | Algorithm code (R2) |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A read mismatch was seen in the current or last run |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element index (0-based) of the first mismatch |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_wdata | output | 1 | RAM write data |
| mem_rdata | input | 1 | RAM read data, valid one cycle after `mem_re` |

## Verification
A wrong element, slot or repeat counter shows up at the memory ports in the very cycle the state goes wrong. The address, the direction or the write enable then departs from the reference sequence, which the bench checks on every clock. A wrong pending-read register shows up two cycles after the read, as a `fail` that rises too early, too late or not at all. It can also show up as a wrong `fail_addr` or `fail_elem`, which the bench compares on the `done` cycle. A wrong end-of-algorithm decision shows up as an operation count that differs from the algorithm's length, or as a `done` pulse in the wrong cycle.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int unsigned OPS_MAX  = 3;
    localparam int unsigned ELEM_W   = 3;
    localparam int unsigned ALG_LAST = 5;

    typedef enum logic [2:0] {
        ALG_SCAN    = 3'd0,
        ALG_MATSP   = 3'd1,
        ALG_MATSPP  = 3'd2,
        ALG_MARCHCM = 3'd3,
        ALG_PMOVI   = 3'd4,
        ALG_HAMMER  = 3'd5
    } alg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_st_e;

    // One March element: slot 0 sits in bit 0 of each field
    typedef struct packed {
        logic [1:0]         nops;
        logic               down;
        logic [OPS_MAX-1:0] wr;
        logic [OPS_MAX-1:0] val;
        logic [OPS_MAX-1:0] ham;
    } elem_t;

    function automatic elem_t mk_elem(logic [1:0] n, logic dn, logic [2:0] wr,
                                      logic [2:0] val, logic [2:0] ham);
        elem_t d;
        d.nops = n;
        d.down = dn;
        d.wr   = wr;
        d.val  = val;
        d.ham  = ham;
        return d;
    endfunction

    function automatic logic [ELEM_W-1:0] alg_elem_count(alg_e a);
        case (a)
            ALG_SCAN:    return 3'd4;
            ALG_MATSP:   return 3'd3;
            ALG_MATSPP:  return 3'd3;
            ALG_MARCHCM: return 3'd6;
            ALG_PMOVI:   return 3'd5;
            ALG_HAMMER:  return 3'd5;
            default:     return 3'd1;
        endcase
    endfunction

    function automatic elem_t elem_lookup(alg_e a, logic [ELEM_W-1:0] e);
        elem_t d;
        d = mk_elem(2'd1, 1'b0, 3'b001, 3'b000, 3'b000); // up w0
        case (a)
            ALG_SCAN: begin
                case (e)
                    3'd1:    d = mk_elem(2'd1, 1'b0, 3'b000, 3'b000, 3'b000);
                    3'd2:    d = mk_elem(2'd1, 1'b0, 3'b001, 3'b001, 3'b000);
                    3'd3:    d = mk_elem(2'd1, 1'b0, 3'b000, 3'b001, 3'b000);
                    default: ;
                endcase
            end
            ALG_MATSP: begin
                case (e)
                    3'd1:    d = mk_elem(2'd2, 1'b0, 3'b010, 3'b010, 3'b000);
                    3'd2:    d = mk_elem(2'd2, 1'b1, 3'b010, 3'b001, 3'b000);
                    default: ;
                endcase
            end
            ALG_MATSPP: begin
                case (e)
                    3'd1:    d = mk_elem(2'd2, 1'b0, 3'b010, 3'b010, 3'b000);
                    3'd2:    d = mk_elem(2'd3, 1'b1, 3'b010, 3'b001, 3'b000);
                    default: ;
                endcase
            end
            ALG_MARCHCM: begin
                case (e)
                    3'd1:    d = mk_elem(2'd2, 1'b0, 3'b010, 3'b010, 3'b000);
                    3'd2:    d = mk_elem(2'd2, 1'b0, 3'b010, 3'b001, 3'b000);
                    3'd3:    d = mk_elem(2'd2, 1'b1, 3'b010, 3'b010, 3'b000);
                    3'd4:    d = mk_elem(2'd2, 1'b1, 3'b010, 3'b001, 3'b000);
                    3'd5:    d = mk_elem(2'd1, 1'b0, 3'b000, 3'b000, 3'b000);
                    default: ;
                endcase
            end
            ALG_PMOVI: begin
                case (e)
                    3'd0:    d = mk_elem(2'd1, 1'b1, 3'b001, 3'b000, 3'b000);
                    3'd1:    d = mk_elem(2'd3, 1'b0, 3'b010, 3'b110, 3'b000);
                    3'd2:    d = mk_elem(2'd3, 1'b0, 3'b010, 3'b001, 3'b000);
                    3'd3:    d = mk_elem(2'd3, 1'b1, 3'b010, 3'b110, 3'b000);
                    3'd4:    d = mk_elem(2'd3, 1'b1, 3'b010, 3'b001, 3'b000);
                    default: ;
                endcase
            end
            ALG_HAMMER: begin
                case (e)
                    3'd1:    d = mk_elem(2'd3, 1'b0, 3'b010, 3'b110, 3'b010);
                    3'd2:    d = mk_elem(2'd3, 1'b0, 3'b010, 3'b001, 3'b010);
                    3'd3:    d = mk_elem(2'd3, 1'b1, 3'b010, 3'b110, 3'b010);
                    3'd4:    d = mk_elem(2'd3, 1'b1, 3'b010, 3'b001, 3'b010);
                    default: ;
                endcase
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int unsigned WORDS      = 16,
    parameter int unsigned HAMMER_REP = 10,
    localparam int unsigned AW = (WORDS > 2) ? $clog2(WORDS) : 1,
    localparam int unsigned RW = $clog2(HAMMER_REP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        alg_sel,
    output logic              launch,
    output logic              done,
    output logic [AW-1:0]     op_addr,
    output logic              op_we,
    output logic              op_re,
    output logic              op_val,
    output logic [ELEM_W-1:0] op_elem
);

    localparam logic [AW-1:0] ADDR_TOP = AW'(WORDS - 1);

    typedef struct packed {
        seq_st_e           st;
        alg_e              alg;
        logic [ELEM_W-1:0] elem;
        logic [1:0]        slot;
        logic [RW-1:0]     rep;
        logic [AW-1:0]     addr;
        logic              done;
    } seq_t;

    seq_t q, d;

    elem_t       cur;
    elem_t       nxt_elem;
    elem_t       new_elem;
    logic        cur_wr;
    logic        cur_val;
    logic        cur_ham;
    int unsigned cur_reps;
    logic        last_addr;
    logic        sel_ok;

    always_comb begin
        cur      = elem_lookup(q.alg, q.elem);
        nxt_elem = elem_lookup(q.alg, q.elem + 3'd1);
        new_elem = elem_lookup(alg_e'(alg_sel), 3'd0);
        cur_wr   = cur.wr[q.slot];
        cur_val  = cur.val[q.slot];
        cur_ham  = cur.ham[q.slot];
        cur_reps = cur_ham ? HAMMER_REP : 1;
        last_addr = cur.down ? (q.addr == '0) : (q.addr == ADDR_TOP);
        sel_ok   = (32'(alg_sel) <= ALG_LAST);
        launch   = (q.st == ST_IDLE) && start && sel_ok;

        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (launch) begin
                    d.st   = ST_RUN;
                    d.alg  = alg_e'(alg_sel);
                    d.elem = '0;
                    d.slot = '0;
                    d.rep  = '0;
                    d.addr = new_elem.down ? ADDR_TOP : '0;
                end
            end
            ST_RUN: begin
                if (32'(q.rep) + 1 < cur_reps) begin
                    d.rep = q.rep + 1'b1;
                end else begin
                    d.rep = '0;
                    if ({1'b0, q.slot} + 3'd1 < {1'b0, cur.nops}) begin
                        d.slot = q.slot + 2'd1;
                    end else begin
                        d.slot = '0;
                        if (!last_addr) begin
                            d.addr = cur.down ? q.addr - 1'b1 : q.addr + 1'b1;
                        end else if ({1'b0, q.elem} + 4'd1 < {1'b0, alg_elem_count(q.alg)}) begin
                            d.elem = q.elem + 3'd1;
                            d.addr = nxt_elem.down ? ADDR_TOP : '0;
                        end else begin
                            d.st = ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.alg  <= ALG_SCAN;
            q.elem <= '0;
            q.slot <= '0;
            q.rep  <= '0;
            q.addr <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign op_addr = q.addr;
    assign op_we   = (q.st == ST_RUN) && cur_wr;
    assign op_re   = (q.st == ST_RUN) && !cur_wr;
    assign op_val  = (q.st == ST_RUN) && cur_val;
    assign op_elem = q.elem;

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
    import mbist_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic              exp_bit,
    input  logic [AW-1:0]     rd_addr,
    input  logic [ELEM_W-1:0] rd_elem,
    input  logic              mem_rdata,
    output logic              fail,
    output logic [AW-1:0]     fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);

    typedef struct packed {
        logic              pend;
        logic              exp;
        logic [AW-1:0]     paddr;
        logic [ELEM_W-1:0] pelem;
        logic              fail;
        logic [AW-1:0]     faddr;
        logic [ELEM_W-1:0] felem;
    } cmp_t;

    cmp_t q, d;
    logic mismatch;

    always_comb begin
        mismatch = q.pend && (mem_rdata != q.exp);
        d        = q;
        d.pend   = rd_issue;
        d.exp    = exp_bit;
        d.paddr  = rd_addr;
        d.pelem  = rd_elem;
        if (clear) begin
            d.fail  = 1'b0;
            d.faddr = '0;
            d.felem = '0;
        end else if (mismatch && !q.fail) begin
            d.fail  = 1'b1;
            d.faddr = q.paddr;
            d.felem = q.pelem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fail      = q.fail;
    assign fail_addr = q.faddr;
    assign fail_elem = q.felem;

endmodule

// File: rtl/mbist_march_engine.sv
module mbist_march_engine
    import mbist_pkg::*;
#(
    parameter int unsigned WORDS      = 16,
    parameter int unsigned HAMMER_REP = 10,
    localparam int unsigned AW = (WORDS > 2) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    alg_sel,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [2:0]    fail_elem,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic          mem_wdata,
    input  logic          mem_rdata
);

    logic              launch;
    logic              op_val;
    logic [ELEM_W-1:0] op_elem;

    mbist_seq #(
        .WORDS      (WORDS),
        .HAMMER_REP (HAMMER_REP)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .alg_sel (alg_sel),
        .launch  (launch),
        .done    (done),
        .op_addr (mem_addr),
        .op_we   (mem_we),
        .op_re   (mem_re),
        .op_val  (op_val),
        .op_elem (op_elem)
    );

    mbist_cmp #(
        .AW (AW)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .rd_issue  (mem_re),
        .exp_bit   (op_val),
        .rd_addr   (mem_addr),
        .rd_elem   (op_elem),
        .mem_rdata (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem)
    );

    assign mem_wdata = op_val && mem_we;

endmodule

// File: rtl/mbist_chk.sv
module mbist_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [2:0]    fail_elem,
    input logic          mem_we,
    input logic          mem_re
);

    logic op_act;
    assign op_act = mem_we || mem_re;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_act); // R8

    AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(op_act)); // R8

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail); // R7

    AST_FAIL_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_elem))); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_act && !$past(op_act)) |-> !fail); // R10

endmodule

bind mbist_march_engine mbist_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/sim_mbist_march_engine.sv
module sim_mbist_march_engine;

    localparam int WORDS = 16;
    localparam int AW    = 4;
    localparam int HREP  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    alg_sel = 3'd0;
    logic          done, fail, mem_we, mem_re, mem_wdata;
    logic          mem_rdata = 1'b0;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [2:0]    fail_elem;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // fault model of the bench RAM: stuck cells
    bit f_en  [WORDS];
    bit f_val [WORDS];
    logic marr [WORDS];

    // reference sequence
    int q_we[$], q_addr[$], q_dat[$], q_elem[$];
    int fail_idx, fail_a, fail_e;
    bit shadow [WORDS];
    int len_n [6] = '{4, 5, 6, 10, 13, 49};

    mbist_march_engine #(.WORDS(WORDS), .HAMMER_REP(HREP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .done(done), .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) marr[i] <= 1'b0;
        end else begin
            if (mem_we) marr[mem_addr] <= f_en[mem_addr] ? f_val[mem_addr] : mem_wdata;
            if (mem_re) mem_rdata <= f_en[mem_addr] ? f_val[mem_addr] : marr[mem_addr];
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_elem(input int e, input bit dn, input string s);
        for (int i = 0; i < WORDS; i++) begin
            int a;
            a = dn ? WORDS - 1 - i : i;
            for (int k = 0; k < s.len(); k += 2) begin
                byte c;
                int v, reps;
                c    = s[k];
                v    = int'(s[k+1]) - 48;
                reps = (c == "h") ? HREP : 1;
                for (int r = 0; r < reps; r++) begin
                    bit w, seen;
                    w = (c != "r");
                    q_we.push_back(int'(w));
                    q_addr.push_back(a);
                    q_dat.push_back(v);
                    q_elem.push_back(e);
                    if (w) begin
                        shadow[a] = f_en[a] ? f_val[a] : v[0];
                    end else begin
                        seen = f_en[a] ? f_val[a] : shadow[a];
                        if (fail_idx < 0 && seen != v[0]) begin
                            fail_idx = q_we.size() - 1;
                            fail_a   = a;
                            fail_e   = e;
                        end
                    end
                end
            end
        end
    endtask

    task automatic build(input int code);
        q_we.delete(); q_addr.delete(); q_dat.delete(); q_elem.delete();
        fail_idx = -1; fail_a = 0; fail_e = 0;
        for (int i = 0; i < WORDS; i++) shadow[i] = 1'b0;
        case (code)
            0: begin
                add_elem(0, 0, "w0"); add_elem(1, 0, "r0");
                add_elem(2, 0, "w1"); add_elem(3, 0, "r1");
            end
            1: begin
                add_elem(0, 0, "w0"); add_elem(1, 0, "r0w1"); add_elem(2, 1, "r1w0");
            end
            2: begin
                add_elem(0, 0, "w0"); add_elem(1, 0, "r0w1"); add_elem(2, 1, "r1w0r0");
            end
            3: begin
                add_elem(0, 0, "w0");   add_elem(1, 0, "r0w1"); add_elem(2, 0, "r1w0");
                add_elem(3, 1, "r0w1"); add_elem(4, 1, "r1w0"); add_elem(5, 0, "r0");
            end
            4: begin
                add_elem(0, 1, "w0");     add_elem(1, 0, "r0w1r1"); add_elem(2, 0, "r1w0r0");
                add_elem(3, 1, "r0w1r1"); add_elem(4, 1, "r1w0r0");
            end
            default: begin
                add_elem(0, 0, "w0");     add_elem(1, 0, "r0h1r1"); add_elem(2, 0, "r1h0r0");
                add_elem(3, 1, "r0h1r1"); add_elem(4, 1, "r1h0r0");
            end
        endcase
    endtask

    // R3 R4 R5 R6: per-cycle compare of ports against the reference
    task automatic run(input int code, input int mid_code);
        int L, errs, ops, first_t;
        bit exp_f;
        build(code);
        @(negedge clk);
        alg_sel = 3'(code);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        L = q_we.size();
        errs = 0; ops = 0; first_t = -1;
        for (int t = 0; t < L; t++) begin
            bit bad_cyc;
            exp_f = (fail_idx >= 0) && (t >= fail_idx + 2);
            if (mem_we || mem_re) ops++;
            bad_cyc = (int'(mem_we) != q_we[t]) || (int'(mem_re) == q_we[t]) ||
                      (int'(mem_addr) != q_addr[t]) ||
                      (q_we[t] == 1 && int'(mem_wdata) != q_dat[t]) ||
                      (fail != exp_f) || done;
            if (bad_cyc) begin
                errs++;
                if (first_t < 0) begin
                    first_t = t;
                    $display("  mismatch t=%0d we=%0d re=%0d addr=%0d wd=%0d fail=%0d | exp we=%0d addr=%0d d=%0d fail=%0d",
                             t, mem_we, mem_re, mem_addr, mem_wdata, fail,
                             q_we[t], q_addr[t], q_dat[t], exp_f);
                end
            end
            if (t == 5 && mid_code >= 0) begin
                alg_sel = 3'(mid_code); // R9: ignored while running
                start   = 1'b1;
            end else begin
                start   = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(errs == 0, "R3/R4/R5/R6", $sformatf("alg %0d op sequence mismatches", code), errs, 0);
        chk(ops == len_n[code] * WORDS, "R2", $sformatf("alg %0d op count", code), ops, len_n[code] * WORDS);
        chk(!(mem_we || mem_re) && !done, "R8", "gap cycle after last op quiet", int'(mem_we || mem_re || done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R8", "done pulse", int'(done), 1);
        exp_f = (fail_idx >= 0);
        chk(fail == exp_f, "R6", $sformatf("alg %0d fail at done", code), int'(fail), int'(exp_f));
        if (exp_f) begin
            chk(int'(fail_addr) == fail_a, "R7", "first fail address", int'(fail_addr), fail_a);
            chk(int'(fail_elem) == fail_e, "R7", "first fail element", int'(fail_elem), fail_e);
        end
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", int'(done), 0);
    endtask

    task automatic clear_faults();
        for (int i = 0; i < WORDS; i++) begin
            f_en[i]  = 1'b0;
            f_val[i] = 1'b0;
        end
    endtask

    // R9: start with an unsupported code
    task automatic bad_code(input int code, input bit fail_exp);
        int acts;
        acts = 0;
        @(negedge clk);
        alg_sel = 3'(code);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (mem_we || mem_re || done || (fail != fail_exp)) acts++;
            @(negedge clk);
        end
        chk(acts == 0, "R9", $sformatf("code %0d ignored", code), acts, 0);
    endtask

    initial begin
        clear_faults();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !fail && !mem_we && !mem_re, "R1", "outputs in reset",
            int'({done, fail, mem_we, mem_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fail_addr == '0 && fail_elem == '0 && !done && !fail, "R1", "state after reset",
            int'({fail_addr, fail_elem}), 0);

        // R2 R3: every algorithm on a good memory
        for (int c = 0; c < 6; c++) run(c, -1);

        // R6 R7: stuck-at-1 cell under MATS+
        f_en[3] = 1'b1; f_val[3] = 1'b1;
        run(1, -1);
        // R9: bad codes leave the latched failure alone
        bad_code(6, 1'b1);
        bad_code(7, 1'b1);
        clear_faults();
        // R9 R10: clean run clears fail, mid-run start ignored
        run(3, 5);

        // R7: two faults, the first in order wins
        f_en[12] = 1'b1; f_val[12] = 1'b0;
        f_en[7]  = 1'b1; f_val[7]  = 1'b1;
        run(3, -1);
        clear_faults();
        f_en[0] = 1'b1; f_val[0] = 1'b0;
        run(4, -1);
        clear_faults();
        f_en[9] = 1'b1; f_val[9] = 1'b0;
        run(2, -1);
        clear_faults();
        // R5: hammer with a stuck-at-1 on the top cell
        f_en[15] = 1'b1; f_val[15] = 1'b1;
        run(5, -1);
        clear_faults();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule